// File: doc/BRIEF.md
# Fuse Programming Request Gate

This block sits between a register front end and a one-time-programmable fuse array. Each request carries a 13-bit fuse address split into a column, a row and an array select, together with the protection state in force at that moment: a register write lock, a programming enable, a lock fuse that protects the helper-data arrays, and a lock fuse that protects the key-store rows. The gate decodes and remaps the address, walks a fixed-priority chain of protection checks, and then does one of two things. It either fires a single set-bit strobe at the array with the remapped bit index, or it refuses the request and reports why.

A request is accepted only while the gate is idle. A refused request finishes one cycle after acceptance. A granted request fires its strobe one cycle after acceptance and reports one cycle after that. In that report the array's pass/fail answer decides the error flag. The done pulse marks the end of every request, whatever its outcome. The error flag and its cause code hold until the next report.

The controller is a three-state machine. The states are IDLE, FIRE and REPORT, and there are four transitions:
- IDLE to FIRE, on a request that passes every check;
- IDLE to REPORT, on a request that fails a check;
- FIRE to REPORT, always;
- REPORT to IDLE, always.

IDLE holds when no request arrives.

Top module: `fuse_pgm_gate`

## Requirements
- R1: The address holds the column in bits 4:0, the row in bits 10:5 and the array select in bits 12:11. Array select 0 passes unchanged, and selects 2 and 3 become 1 and 2. `bit_index_o` = {remapped select, row, column} is loaded on every accepted request with a valid select and is visible from the cycle after acceptance.
- R2: Array select 1 is an invalid address. It yields cause 1, fires no strobe and leaves `bit_index_o` unchanged.
- R3: When several checks fail, the reported cause is the first failing one in this order: invalid address (1), register write lock set (2), programming enable clear (3), helper lock set for selects 2 or 3 (4), key lock (5).
- R4: With `key_lock_i` set, a request to array select 0 with row 24 to 31 (any column) is refused with cause 5. Row 23, and arrays 2 and 3, are not affected by the key lock.
- R5: `helper_lock_i` refuses only requests to array selects 2 and 3. Requests to array 0 pass regardless of it.
- R6: `set_strobe_o` is high for exactly one cycle, the cycle after a request is accepted with every check passing. It never rises on a refused request.
- R7: A refused request raises `done_o` in the cycle after acceptance. A granted request raises `done_o` in the cycle after its strobe. `done_o` is always a single-cycle pulse.
- R8: `error_o` is set and `err_cause_o` gives the cause when a check fails. If `set_fail_i` is high during the strobe cycle, the cause is 6. A successful set clears them to 0 / cause 0. Both hold until the next report.
- R9: `busy_o` is high from the cycle after acceptance through the done cycle. Requests raised while busy are ignored: they produce no strobe, no done and no change of `bit_index_o`.
- R10: After reset, all outputs are 0 and the gate is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Programming request, sampled while idle |
| addr_i | input | 13 | Fuse address {array select, row, column} |
| regs_locked_i | input | 1 | Register block write-locked |
| pgm_en_i | input | 1 | Programming enabled |
| helper_lock_i | input | 1 | Helper-data arrays write-lock fuse |
| key_lock_i | input | 1 | Key-store rows write-lock fuse |
| set_fail_i | input | 1 | Array reports the set failed, valid in the strobe cycle |
| bit_index_o | output | 13 | Remapped bit index of the last valid request |
| set_strobe_o | output | 1 | Single-cycle set-bit strobe to the array |
| done_o | output | 1 | Single-cycle end-of-request pulse |
| error_o | output | 1 | Last request failed |
| err_cause_o | output | 3 | Cause of the last result (0 = success) |
| busy_o | output | 1 | Request in flight |

## Verification
The state machine is the block's only memory besides the captured index and cause. A wrong state therefore shows up at the ports within one or two cycles of a request, in one of three ways: a strobe on a refused request, a missing or doubled done pulse, or `busy_o` failing to drop after the done cycle. A wrong priority or remap shows up in the cause code or bit index reported in the done cycle of the request that exposes it. Random requests with weighted lock states are mixed with directed ones at rows 23, 24 and 31 and at each array select.

// File: rtl/fuse_gate_pkg.sv
package fuse_gate_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE        = 3'd0,
        CAUSE_BAD_ADDR    = 3'd1,
        CAUSE_REG_LOCK    = 3'd2,
        CAUSE_PGM_OFF     = 3'd3,
        CAUSE_HELPER_LOCK = 3'd4,
        CAUSE_KEY_LOCK    = 3'd5,
        CAUSE_SET_FAIL    = 3'd6
    } gate_cause_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRE   = 2'd1,
        ST_REPORT = 2'd2
    } gate_state_e;

endpackage

// File: rtl/fuse_addr_map.sv
// Splits the fuse address, validates the array select and closes the gap
// left by the skipped array code.
module fuse_addr_map #(
    parameter int COL_W       = 5,
    parameter int ROW_W       = 6,
    parameter int SEL_W       = 2,
    parameter int ARRAY_CODES = 4,
    parameter int SKIP_SEL    = 1,
    localparam int ADDR_W     = SEL_W + ROW_W + COL_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              valid_o,
    output logic              helper_arr_o,
    output logic [ROW_W-1:0]  row_o,
    output logic [ADDR_W-1:0] index_o
);
    localparam logic [SEL_W-1:0] SKIP = SEL_W'(SKIP_SEL);

    logic [SEL_W-1:0] sel;
    logic [SEL_W-1:0] sel_m;
    logic             in_range;

    assign sel   = addr_i[ADDR_W-1 -: SEL_W];
    assign row_o = addr_i[COL_W +: ROW_W];

    generate
        if ((1 << SEL_W) > ARRAY_CODES) begin : g_range_chk
            assign in_range = (int'(sel) < ARRAY_CODES);
        end else begin : g_full_range
            assign in_range = 1'b1;
        end
    endgenerate

    always_comb begin
        valid_o      = in_range && (sel != SKIP);
        helper_arr_o = (sel > SKIP);
        sel_m        = helper_arr_o ? sel - 1'b1 : sel;
        index_o      = {sel_m, addr_i[ROW_W+COL_W-1:0]};
    end

endmodule

// File: rtl/fuse_guard_chain.sv
// Fixed-priority protection chain; reports the first failing check.
module fuse_guard_chain
    import fuse_gate_pkg::*;
#(
    parameter int ROW_W      = 6,
    parameter int KEY_ROW_LO = 24,
    parameter int KEY_ROW_HI = 31
) (
    input  logic             addr_valid_i,
    input  logic             helper_arr_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic             regs_locked_i,
    input  logic             pgm_en_i,
    input  logic             helper_lock_i,
    input  logic             key_lock_i,
    output gate_cause_e      cause_o
);
    localparam logic [ROW_W-1:0] KLO = ROW_W'(KEY_ROW_LO);
    localparam logic [ROW_W-1:0] KHI = ROW_W'(KEY_ROW_HI);

    logic in_key_rows;

    assign in_key_rows = !helper_arr_i && (row_i >= KLO) && (row_i <= KHI);

    always_comb begin
        if (!addr_valid_i)
            cause_o = CAUSE_BAD_ADDR;
        else if (regs_locked_i)
            cause_o = CAUSE_REG_LOCK;
        else if (!pgm_en_i)
            cause_o = CAUSE_PGM_OFF;
        else if (helper_arr_i && helper_lock_i)
            cause_o = CAUSE_HELPER_LOCK;
        else if (key_lock_i && in_key_rows)
            cause_o = CAUSE_KEY_LOCK;
        else
            cause_o = CAUSE_NONE;
    end

endmodule

// File: rtl/fuse_pgm_gate.sv
module fuse_pgm_gate
    import fuse_gate_pkg::*;
#(
    parameter int COL_W       = 5,
    parameter int ROW_W       = 6,
    parameter int SEL_W       = 2,
    parameter int ARRAY_CODES = 4,
    parameter int SKIP_SEL    = 1,
    parameter int KEY_ROW_LO  = 24,
    parameter int KEY_ROW_HI  = 31,
    localparam int ADDR_W     = SEL_W + ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              regs_locked_i,
    input  logic              pgm_en_i,
    input  logic              helper_lock_i,
    input  logic              key_lock_i,
    input  logic              set_fail_i,
    output logic [ADDR_W-1:0] bit_index_o,
    output logic              set_strobe_o,
    output logic              done_o,
    output logic              error_o,
    output logic [2:0]        err_cause_o,
    output logic              busy_o
);
    gate_state_e       state_q, state_d;
    gate_cause_e       chk_cause, cause_q;
    logic              addr_valid, helper_arr;
    logic [ROW_W-1:0]  row;
    logic [ADDR_W-1:0] mapped;
    logic              accept;
    logic              strobe_q, done_q;
    logic [ADDR_W-1:0] index_q;

    fuse_addr_map #(
        .COL_W(COL_W), .ROW_W(ROW_W), .SEL_W(SEL_W),
        .ARRAY_CODES(ARRAY_CODES), .SKIP_SEL(SKIP_SEL)
    ) u_map (
        .addr_i      (addr_i),
        .valid_o     (addr_valid),
        .helper_arr_o(helper_arr),
        .row_o       (row),
        .index_o     (mapped)
    );

    fuse_guard_chain #(
        .ROW_W(ROW_W), .KEY_ROW_LO(KEY_ROW_LO), .KEY_ROW_HI(KEY_ROW_HI)
    ) u_guard (
        .addr_valid_i (addr_valid),
        .helper_arr_i (helper_arr),
        .row_i        (row),
        .regs_locked_i(regs_locked_i),
        .pgm_en_i     (pgm_en_i),
        .helper_lock_i(helper_lock_i),
        .key_lock_i   (key_lock_i),
        .cause_o      (chk_cause)
    );

    assign accept = (state_q == ST_IDLE) && req_i;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_i) state_d = (chk_cause == CAUSE_NONE) ? ST_FIRE : ST_REPORT;
            ST_FIRE:   state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            done_q   <= 1'b0;
            cause_q  <= CAUSE_NONE;
            index_q  <= '0;
        end else begin
            strobe_q <= accept && (chk_cause == CAUSE_NONE);
            done_q   <= (accept && (chk_cause != CAUSE_NONE)) || (state_q == ST_FIRE);
            if (accept && (chk_cause != CAUSE_NONE))
                cause_q <= chk_cause;
            else if (state_q == ST_FIRE)
                cause_q <= set_fail_i ? CAUSE_SET_FAIL : CAUSE_NONE;
            if (accept && addr_valid)
                index_q <= mapped;
        end
    end

    assign set_strobe_o = strobe_q;
    assign done_o       = done_q;
    assign err_cause_o  = cause_q;
    assign error_o      = (cause_q != CAUSE_NONE);
    assign bit_index_o  = index_q;
    assign busy_o       = (state_q != ST_IDLE);

    // ---------------- assertions ----------------
    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_strobe_o |=> !set_strobe_o);

    assert_strobe_then_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set_strobe_o |=> done_o);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_bad_addr_refused_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !busy_o && addr_i[ADDR_W-1 -: SEL_W] == SEL_W'(SKIP_SEL))
        |=> (done_o && error_o && !set_strobe_o && err_cause_o == 3'(CAUSE_BAD_ADDR)));

    assert_success_needs_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !error_o) |-> $past(set_strobe_o));

    assert_strobe_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_strobe_o |-> busy_o);

    assert_index_stable_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(bit_index_o));

endmodule

// File: tb/fuse_pgm_gate_bench.sv
`timescale 1ns/1ps
module fuse_pgm_gate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [12:0] addr_i = '0;
    logic        regs_locked_i = 1'b0, pgm_en_i = 1'b0, helper_lock_i = 1'b0;
    logic        key_lock_i = 1'b0, set_fail_i = 1'b0;
    logic [12:0] bit_index_o;
    logic        set_strobe_o, done_o, error_o, busy_o;
    logic [2:0]  err_cause_o;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    logic [12:0] exp_idx = '0;

    always #10 clk = ~clk;   // 50 MHz

    fuse_pgm_gate u_fuse_pgm_gate (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i),
        .regs_locked_i(regs_locked_i), .pgm_en_i(pgm_en_i),
        .helper_lock_i(helper_lock_i), .key_lock_i(key_lock_i),
        .set_fail_i(set_fail_i), .bit_index_o(bit_index_o),
        .set_strobe_o(set_strobe_o), .done_o(done_o), .error_o(error_o),
        .err_cause_o(err_cause_o), .busy_o(busy_o));

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int model_cause(logic [12:0] a, bit rl, bit pe, bit hl, bit kl, bit sf);
        logic [1:0] s = a[12:11];
        logic [5:0] r = a[10:5];
        if (s == 2'd1) return 1;
        if (rl) return 2;
        if (!pe) return 3;
        if (s >= 2'd2 && hl) return 4;
        if (s == 2'd0 && kl && r >= 6'd24 && r <= 6'd31) return 5;
        if (sf) return 6;
        return 0;
    endfunction

    function automatic logic [12:0] model_index(logic [12:0] a);
        logic [1:0] s = a[12:11];
        return {(s == 2'd0) ? 2'd0 : s - 2'd1, a[10:0]};
    endfunction

    // Inputs driven at negedge; outputs sampled at negedge.
    task automatic do_req(string tag, logic [12:0] a, bit rl, bit pe, bit hl,
                          bit kl, bit sf, bit ign);
        int ec;
        ec = model_cause(a, rl, pe, hl, kl, sf);
        @(negedge clk);
        addr_i = a; regs_locked_i = rl; pgm_en_i = pe; helper_lock_i = hl;
        key_lock_i = kl; req_i = 1'b1;
        @(negedge clk);                               // after accept edge
        if (ec != 1) exp_idx = model_index(a);
        check(tag, "busy after accept R9", 32'(busy_o), 1);
        req_i = ign; addr_i = ~a; regs_locked_i = 0; pgm_en_i = 1; key_lock_i = 0; helper_lock_i = 0;
        if (ec >= 1 && ec <= 5) begin
            check(tag, "no strobe on refusal R6", 32'(set_strobe_o), 0);
            check(tag, "done R7", 32'(done_o), 1);
            check(tag, "error R8", 32'(error_o), 1);
            check(tag, "cause R3", 32'(err_cause_o), 32'(ec));
            check(tag, "index R1", 32'(bit_index_o), 32'(exp_idx));
        end else begin
            check(tag, "strobe R6", 32'(set_strobe_o), 1);
            check(tag, "no early done R7", 32'(done_o), 0);
            check(tag, "index R1", 32'(bit_index_o), 32'(exp_idx));
            set_fail_i = sf;
            @(negedge clk);
            set_fail_i = 0;
            req_i = 0;
            check(tag, "strobe single R6", 32'(set_strobe_o), 0);
            check(tag, "done after strobe R7", 32'(done_o), 1);
            check(tag, "error R8", 32'(error_o), 32'(sf));
            check(tag, "cause R8", 32'(err_cause_o), 32'(ec));
        end
        @(negedge clk);
        req_i = 0;
        check(tag, "done single R7", 32'(done_o), 0);
        check(tag, "idle R9", 32'(busy_o), 0);
        check(tag, "no stray strobe R9", 32'(set_strobe_o), 0);
        check(tag, "index held R9", 32'(bit_index_o), 32'(exp_idx));
        check(tag, "cause held R8", 32'(err_cause_o), 32'(ec));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240917));
        repeat (3) @(negedge clk);
        check("R10", "strobe", 32'(set_strobe_o), 0);
        check("R10", "done", 32'(done_o), 0);
        check("R10", "error", 32'(error_o), 0);
        check("R10", "busy", 32'(busy_o), 0);
        check("R10", "index", 32'(bit_index_o), 0);
        rst_n = 1'b1;

        // R1 remap of each valid select
        do_req("R1", {2'd0, 6'd5, 5'd7},   0, 1, 0, 0, 0, 0);
        do_req("R1", {2'd2, 6'd40, 5'd31}, 0, 1, 0, 0, 0, 0);
        do_req("R1", {2'd3, 6'd63, 5'd0},  0, 1, 0, 0, 0, 0);
        // R2 skipped array
        do_req("R2", {2'd1, 6'd3, 5'd3},   0, 1, 0, 0, 0, 0);
        // R3 priority
        do_req("R3", {2'd1, 6'd24, 5'd0},  1, 0, 1, 1, 0, 0);
        do_req("R3", {2'd2, 6'd1, 5'd1},   1, 0, 1, 0, 0, 0);
        do_req("R3", {2'd2, 6'd1, 5'd1},   0, 0, 1, 0, 0, 0);
        do_req("R3", {2'd3, 6'd1, 5'd1},   0, 1, 1, 1, 0, 0);
        // R4 key rows
        do_req("R4", {2'd0, 6'd24, 5'd0},  0, 1, 0, 1, 0, 0);
        do_req("R4", {2'd0, 6'd31, 5'd31}, 0, 1, 0, 1, 0, 0);
        do_req("R4", {2'd0, 6'd23, 5'd31}, 0, 1, 0, 1, 0, 0);
        do_req("R4", {2'd0, 6'd32, 5'd0},  0, 1, 0, 1, 0, 0);
        do_req("R4", {2'd2, 6'd24, 5'd4},  0, 1, 0, 1, 0, 0);
        // R5 helper lock on array 0
        do_req("R5", {2'd0, 6'd10, 5'd2},  0, 1, 1, 0, 0, 0);
        // R8 array failure then success clears
        do_req("R8", {2'd0, 6'd9, 5'd9},   0, 1, 0, 0, 1, 0);
        do_req("R8", {2'd0, 6'd9, 5'd10},  0, 1, 0, 0, 0, 0);
        // R9 requests while busy ignored (granted and refused paths)
        do_req("R9", {2'd3, 6'd2, 5'd2},   0, 1, 0, 0, 0, 1);
        do_req("R9", {2'd0, 6'd2, 5'd2},   1, 1, 0, 0, 0, 1);

        for (int i = 0; i < 400; i++) begin
            do_req("R3", 13'($urandom),
                   ($urandom % 8) == 0, ($urandom % 8) != 0,
                   ($urandom % 4) == 0, ($urandom % 2) == 1,
                   ($urandom % 6) == 0, ($urandom % 5) == 0);
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule